// File: doc/BRIEF.md
# Memory-Indirect Register Load Sequencer

This block runs one family of CPU instructions, each of which fills a 16- or 24-bit register (BC, DE or HL) from an absolute address carried in the instruction stream. A pulse on `start` hands it a program counter. It then reads one byte per cycle through a byte-wide memory port: first any size-override prefix, then the opcode bytes, then two or three address bytes, and finally two or three data bytes. The data bytes are written into the chosen register, lowest byte first. Memory reads are combinational: a byte placed on `mem_rdata` is used in the same cycle as its address.

A global mode input selects 16-bit or 24-bit operation. A single prefix byte can override it for one instruction, and it can set the operand size and the data size separately. When the address is short, its upper byte comes from a base-page input, from zero, or from the instruction itself, according to the rules below. Condition flags play no part and are neither read nor written.

Top module: `absload_seq`

## Requirements
- R1: After reset, `bc`, `de` and `hl` are zero and `busy`, `done`, `bad_op` and `mem_rd` are low.
- R2: With no prefix and `adl`=0, the byte sequence ED, kk, nn, mm reads two data bytes at {base,mm,nn} into bits 15:0 of the target register. Bits 23:16 keep their old value. The instruction spends 6 read cycles.
- R3: With no prefix and `adl`=1, the byte sequence ED, kk, nn, mm, MM reads three data bytes at {MM,mm,nn} into all 24 bits of the target. It spends 8 read cycles.
- R4: Prefix 0x5B selects a 3-byte operand and long data whatever the value of `adl`. The address {MM,mm,nn} is used in full, and the BC/DE form takes 9 read cycles.
- R5: Prefix 0x40 selects a 2-byte operand and short data whatever the value of `adl`. The address is {base,mm,nn}, and the BC/DE form takes 7 read cycles.
- R6: Prefix 0x52 selects a 3-byte operand with short data. The third operand byte is fetched and discarded, and the address is {base,mm,nn}.
- R7: Prefix 0x49 selects a 2-byte operand with long data. The address is {0x00,mm,nn}, and the base input is not used.
- R8: Opcode 0x2A loads HL directly, with no ED byte. It follows the same prefix and size rules and takes one read cycle fewer than the matching BC/DE form (5, 7, 8 and 6 cycles).
- R9: After ED, the byte 0x4B selects BC and 0x5B selects DE. Any other byte at that position aborts the instruction, and so does an unknown first opcode or a second prefix. An abort raises `bad_op` for one cycle and leaves every register unchanged.
- R10: `done` is a single-cycle pulse in the cycle after the last data read. In that same cycle `busy` is low and the new register value is visible. A register changes only in a cycle where `done` is high.
- R11: Data bytes are read at ea, ea+1 and then ea+2, using 24-bit address arithmetic.
- R12: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction at `start_pc` (only acted on when idle) |
| start_pc | input | 24 | Address of the first instruction byte |
| adl | input | 1 | Global mode: 1 = 24-bit, 0 = 16-bit |
| base | input | 8 | Base-page byte used for short addresses |
| mem_addr | output | 24 | Memory read address |
| mem_rd | output | 1 | Read strobe, high in every busy cycle |
| mem_rdata | input | 8 | Read data for `mem_addr`, same cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after a completed load |
| bad_op | output | 1 | One-cycle pulse after an aborted instruction |
| bc | output | 24 | Register BC |
| de | output | 24 | Register DE |
| hl | output | 24 | Register HL |

## Verification
Most internal faults in this block change the number of bytes it reads. A wrong operand-size flag, a wrong state transition or a decode slip makes the instruction run one cycle long or short, and that is visible in the `mem_rd` count of the very instruction that hit the fault. A wrong upper address byte or a wrong offset sends the data reads to different locations. Because the memory model returns a distinct byte for each address, the register value seen on the `done` cycle exposes this at once. A lost upper-byte preserve, or a write to the wrong target, shows up in the same cycle in one of the three register outputs.

// File: rtl/absload_seq.sv
module absload_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] start_pc,
  input  logic        adl,
  input  logic [7:0]  base,
  output logic [23:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        bad_op,
  output logic [23:0] bc,
  output logic [23:0] de,
  output logic [23:0] hl
);
  localparam logic [7:0] OP_ESC  = 8'hED;
  localparam logic [7:0] OP_HL   = 8'h2A;
  localparam logic [7:0] KK_BC   = 8'h4B;
  localparam logic [7:0] KK_DE   = 8'h5B;
  localparam logic [7:0] PF_LL   = 8'h5B;
  localparam logic [7:0] PF_SS   = 8'h40;
  localparam logic [7:0] PF_LS   = 8'h52;
  localparam logic [7:0] PF_SL   = 8'h49;

  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_KK, S_A0, S_A1, S_A2, S_D0, S_D1, S_D2
  } state_t;

  state_t      st;
  logic [23:0] pc, ea;
  logic [7:0]  base_q, d0, d1;
  logic        imm_l, dat_l, pfx;
  logic [1:0]  dst;
  logic [23:0] bc_q, de_q, hl_q;
  logic        done_q, bad_q;

  wire [7:0] b = mem_rdata;
  wire in_data = (st == S_D0) || (st == S_D1) || (st == S_D2);
  wire [23:0] off = (st == S_D1) ? 24'd1 : (st == S_D2) ? 24'd2 : 24'd0;
  wire is_pfx = (b == PF_LL) || (b == PF_SS) || (b == PF_LS) || (b == PF_SL);
  wire wr_en = ((st == S_D1) && !dat_l) || (st == S_D2);

  logic [23:0] old_v, new_v;
  always_comb begin
    case (dst)
      2'd0:    old_v = bc_q;
      2'd1:    old_v = de_q;
      default: old_v = hl_q;
    endcase
    new_v = dat_l ? {b, d1, d0} : {old_v[23:16], b, d0};
  end

  assign mem_rd   = (st != S_IDLE);
  assign busy     = (st != S_IDLE);
  assign mem_addr = in_data ? ea + off : pc;
  assign done     = done_q;
  assign bad_op   = bad_q;
  assign bc       = bc_q;
  assign de       = de_q;
  assign hl       = hl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= '0;
      ea <= '0;
      base_q <= '0;
      d0 <= '0;
      d1 <= '0;
      imm_l <= 1'b0;
      dat_l <= 1'b0;
      pfx <= 1'b0;
      dst <= '0;
      bc_q <= '0;
      de_q <= '0;
      hl_q <= '0;
      done_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      bad_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pc <= start_pc;
          base_q <= base;
          imm_l <= adl;
          dat_l <= adl;
          pfx <= 1'b0;
          st <= S_OP;
        end
        S_OP: begin
          pc <= pc + 24'd1;
          if (is_pfx && !pfx) begin
            pfx <= 1'b1;
            imm_l <= (b == PF_LL) || (b == PF_LS);
            dat_l <= (b == PF_LL) || (b == PF_SL);
          end else if (b == OP_ESC) begin
            st <= S_KK;
          end else if (b == OP_HL) begin
            dst <= 2'd2;
            st <= S_A0;
          end else begin
            bad_q <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_KK: begin
          pc <= pc + 24'd1;
          if (b == KK_BC) begin
            dst <= 2'd0;
            st <= S_A0;
          end else if (b == KK_DE) begin
            dst <= 2'd1;
            st <= S_A0;
          end else begin
            bad_q <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_A0: begin
          pc <= pc + 24'd1;
          ea[7:0] <= b;
          st <= S_A1;
        end
        S_A1: begin
          pc <= pc + 24'd1;
          ea[15:8] <= b;
          if (imm_l) st <= S_A2;
          else begin
            ea[23:16] <= dat_l ? 8'h00 : base_q;
            st <= S_D0;
          end
        end
        S_A2: begin
          pc <= pc + 24'd1;
          ea[23:16] <= dat_l ? b : base_q;
          st <= S_D0;
        end
        S_D0: begin
          d0 <= b;
          st <= S_D1;
        end
        S_D1: begin
          d1 <= b;
          st <= dat_l ? S_D2 : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (wr_en) begin
        done_q <= 1'b1;
        case (dst)
          2'd0:    bc_q <= new_v;
          2'd1:    de_q <= new_v;
          default: hl_q <= new_v;
        endcase
      end
    end
  end
endmodule

module absload_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_rd,
  input logic        done,
  input logic        bad_op,
  input logic [23:0] bc,
  input logic [23:0] de,
  input logic [23:0] hl
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rd));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bc) || !$stable(de) || !$stable(hl)) |-> done);
  a_r9_bad_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && bad_op));
  a_r9_bad_single: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> !bad_op);
  a_r12_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd == busy);
endmodule

bind absload_seq absload_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .done(done),
  .bad_op(bad_op), .bc(bc), .de(de), .hl(hl)
);

// File: tb/absload_seq_bench.sv
module absload_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_pc = '0;
  logic        adl = 1'b0;
  logic [7:0]  base = '0;
  logic [23:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        busy, done, bad_op;
  logic [23:0] bc, de, hl;

  localparam logic [23:0] PC0 = 24'hF00010;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  prog [0:7];
  logic [23:0] e_bc = '0, e_de = '0, e_hl = '0;

  always #5 clk = ~clk;

  absload_seq u_absload_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc), .adl(adl),
    .base(base), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .bad_op(bad_op), .bc(bc), .de(de), .hl(hl)
  );

  function automatic logic [7:0] dat(input logic [23:0] a);
    return ((a[7:0] * 8'd5) ^ (a[15:8] * 8'd3)) + (a[23:16] ^ 8'h5A);
  endfunction

  logic [23:0] poff;
  always_comb begin
    poff = mem_addr - PC0;
    mem_rdata = (poff < 24'd8) ? prog[poff[2:0]] : dat(mem_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run(input bit poke, output int cyc, output bit got_done, output bit got_bad);
    int guard;
    cyc = 0; got_done = 0; got_bad = 0; guard = 0;
    start_pc = PC0;
    @(negedge clk);
    start = 1'b1;
    while (1) begin
      @(negedge clk);
      start = 1'b0;
      start_pc = PC0;
      if (mem_rd) cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1;
        start_pc = 24'h000000;
      end
      if (done || bad_op) begin
        got_done = done; got_bad = bad_op;
        break;
      end
      guard++;
      if (guard > 40) begin
        check("R10 watchdog", 0, 1);
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic regs_check(input string req);
    check(req, bc, e_bc);
    check(req, de, e_de);
    check(req, hl, e_hl);
  endtask

  initial begin
    #200000;
    check("watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] pbytes [0:4];
    logic [7:0] seeds [0:2][0:2];
    pbytes[0] = 8'h00; pbytes[1] = 8'h5B; pbytes[2] = 8'h40; pbytes[3] = 8'h52; pbytes[4] = 8'h49;
    seeds[0][0] = 8'h34; seeds[0][1] = 8'h12; seeds[0][2] = 8'h56;
    seeds[1][0] = 8'hFF; seeds[1][1] = 8'hFF; seeds[1][2] = 8'hA7;
    seeds[2][0] = 8'h00; seeds[2][1] = 8'h80; seeds[2][2] = 8'h01;
    base = 8'h3C;
    for (int i = 0; i < 8; i++) prog[i] = 8'h00;

    repeat (3) @(negedge clk);
    check("R1 bc", bc, 0); check("R1 de", de, 0); check("R1 hl", hl, 0);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 bad_op", bad_op, 0); check("R1 mem_rd", mem_rd, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 5; p++)
        for (int d = 0; d < 3; d++)
          for (int s = 0; s < 3; s++) begin
            int idx, cyc, ecyc;
            bit il, dl, gd, gb;
            logic [23:0] ea, old, nv;
            string tag;
            adl = m[0];
            case (p)
              0: begin il = adl; dl = adl; tag = adl ? "R3" : "R2"; end
              1: begin il = 1; dl = 1; tag = "R4"; end
              2: begin il = 0; dl = 0; tag = "R5"; end
              3: begin il = 1; dl = 0; tag = "R6"; end
              default: begin il = 0; dl = 1; tag = "R7"; end
            endcase
            if (d == 2) tag = {tag, " R8"};
            idx = 0;
            for (int i = 0; i < 8; i++) prog[i] = 8'h00;
            if (p != 0) begin prog[idx] = pbytes[p]; idx++; end
            if (d == 2) begin prog[idx] = 8'h2A; idx++; end
            else begin
              prog[idx] = 8'hED; idx++;
              prog[idx] = (d == 0) ? 8'h4B : 8'h5B; idx++;
            end
            prog[idx] = seeds[s][0]; prog[idx+1] = seeds[s][1]; prog[idx+2] = seeds[s][2];
            ea = {dl ? (il ? seeds[s][2] : 8'h00) : base, seeds[s][1], seeds[s][0]};
            ecyc = (p != 0 ? 1 : 0) + (d == 2 ? 1 : 2) + (il ? 3 : 2) + (dl ? 3 : 2);
            old = (d == 0) ? e_bc : (d == 1) ? e_de : e_hl;
            nv = dl ? {dat(ea + 24'd2), dat(ea + 24'd1), dat(ea)}
                    : {old[23:16], dat(ea + 24'd1), dat(ea)};
            if (d == 0) e_bc = nv; else if (d == 1) e_de = nv; else e_hl = nv;
            run(0, cyc, gd, gb);
            check({tag, " cycles"}, cyc, ecyc);
            check({tag, " R10 done"}, gd, 1);
            check({tag, " R10 busy low"}, busy, 0);
            regs_check({tag, " R11 value"});
            @(negedge clk);
            check("R10 done width", done, 0);
          end

    begin
      int cyc; bit gd, gb; logic [23:0] ea;
      adl = 1'b0;
      for (int i = 0; i < 8; i++) prog[i] = 8'h00;
      prog[0] = 8'hED; prog[1] = 8'h4B; prog[2] = 8'h21; prog[3] = 8'h43;
      ea = {base, 8'h43, 8'h21};
      e_bc = {e_bc[23:16], dat(ea + 24'd1), dat(ea)};
      run(1, cyc, gd, gb);
      check("R12 cycles", cyc, 6);
      regs_check("R12 value");

      prog[0] = 8'hED; prog[1] = 8'h6B;
      run(0, cyc, gd, gb);
      check("R9 bad kk flag", gb, 1); check("R9 bad kk cycles", cyc, 2);
      check("R9 bad kk done", gd, 0);
      regs_check("R9 bad kk regs");
      @(negedge clk);
      check("R9 bad_op width", bad_op, 0);

      prog[0] = 8'h00;
      run(0, cyc, gd, gb);
      check("R9 bad first flag", gb, 1); check("R9 bad first cycles", cyc, 1);
      regs_check("R9 bad first regs");

      prog[0] = 8'h5B; prog[1] = 8'h40;
      run(0, cyc, gd, gb);
      check("R9 double prefix flag", gb, 1); check("R9 double prefix cycles", cyc, 2);
      regs_check("R9 double prefix regs");
    end

    summary();
  end
endmodule